// File: doc/BRIEF.md
# Banked Scratchpad with Lock Atomics

This block is an on-chip scratchpad split into a parameterised number of banks, each one word wide, that serves a whole warp of lane requests in one handshake. Each active lane supplies a word address, an opcode and, for writes, a data word. Lanes that fall into the same bank but target different words cannot be served together. The block replays them over successive passes, one word per bank per pass. Lanes that name the same word are served together in one pass, and a read is broadcast to all of them.

For atomic read-modify-write, every word carries a lock bit and an owner lane. A load-and-lock returns the word and a predicate that is true only when this lane obtained the lock. A lane whose predicate comes back false must reissue the load-and-lock. Only the owning lane can store-and-unlock, which writes the new value and releases the lock. Plain loads and stores ignore the locks.

The request side is valid/ready. A warp is taken on a clock edge where `req_valid` and `req_ready` are both high. While earlier lanes are still pending, `req_ready` stays low, and the requester must hold its warp until it is taken. The response side has no back-pressure: each result appears for exactly one cycle, flagged in `rsp_valid`.

Top module: `smem_banked`

## Requirements
- R1: A word address maps to bank `addr mod BANKS` (the low address bits) and to row `addr / BANKS` inside that bank, so consecutive words fall in consecutive banks.
- R2: A warp is accepted on an edge with `req_valid` and `req_ready` high. If it has any active lane, `busy` is high and `req_ready` low from the next cycle until the last of its results has been delivered, after which `req_ready` returns high.
- R3: Lanes in one bank that target different words are served in successive passes, starting with the word of the lowest pending lane. The results of pass k appear k clock edges after the accepting edge.
- R4: All lanes that target the same word are served in the same pass. `rsp_data` for each of them is the word's value from before that pass, whatever the opcode.
- R5: Every active lane of a warp gets `rsp_valid` exactly once and inactive lanes never do. `rsp_valid` is all zero while the block is idle.
- R6: Opcode 1 (store) writes the lane's data. When several lanes write one word in the same pass, the highest lane's data is kept.
- R7: Opcode 2 (load-and-lock) on an unlocked word grants the lock only to the lowest load-and-lock lane of that pass. That lane gets predicate 1 and becomes the owner, and every other load-and-lock lane on that word gets predicate 0.
- R8: Load-and-lock on a word that is locked at the start of the pass returns predicate 0 and leaves both the lock and the owner unchanged.
- R9: Opcode 3 (store-and-unlock) succeeds only for the lane that owns the word's lock: it writes the data, clears the lock and returns predicate 1. For any other lane it returns predicate 0 and changes neither the word nor the lock.
- R10: Opcode 0 (load) and opcode 1 (store) always return predicate 1. After reset, every word is zero, no word is locked and the block is idle and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block can take a warp |
| req_active | input | LANES | Per-lane participation mask |
| req_addr | input | LANES*AW | Per-lane word address, lane l at bits [l*AW +: AW] |
| req_op | input | LANES*2 | Per-lane opcode: 0 load, 1 store, 2 load-and-lock, 3 store-and-unlock |
| req_wdata | input | LANES*DW | Per-lane write data |
| busy | output | 1 | Replay passes still pending |
| rsp_valid | output | LANES | Lanes whose result is presented this cycle |
| rsp_pred | output | LANES | Per-lane success predicate |
| rsp_data | output | LANES*DW | Per-lane word value from before the pass |

## Verification
The bench runs thousands of random warps on a four-lane, four-bank setup. Addresses are drawn from only sixteen words, so bank conflicts, shared words and lock contention happen in most warps. A model in the bench computes the pass number, data and predicate for every lane. A design that ranked the replay by the wrong lane, or that let a lane on a different word block lanes sharing the leader's word, would deliver results in the wrong cycle. Granting a second load-and-lock in the same pass, honouring a store-and-unlock from a lane that does not own the lock, or letting the lowest writer win would show up as wrong predicates or as stale data in later loads. Directed warps cover full broadcast, a four-way conflict in one bank, interleaved word orders, and a complete lock, fail, unlock and relock sequence.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [1:0] {
    OP_LD   = 2'd0,
    OP_ST   = 2'd1,
    OP_LDLK = 2'd2,
    OP_STUL = 2'd3
  } smem_op_e;
endpackage

// File: rtl/smem_pick.sv
// Chooses, for each bank, the word of its lowest pending lane and serves
// every pending lane that targets that same word.
module smem_pick #(
  parameter int LANES = 32,
  parameter int AW    = 8,
  parameter int BW    = 5
) (
  input  logic [LANES-1:0]    pending,
  input  logic [LANES*AW-1:0] addr,
  output logic [LANES-1:0]    served
);
  logic [AW-1:0] lead [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      lead[l] = addr[l*AW +: AW];
      for (int j = l - 1; j >= 0; j--) begin
        if (pending[j] && addr[j*AW +: BW] == addr[l*AW +: BW])
          lead[l] = addr[j*AW +: AW];
      end
      served[l] = pending[l] && (lead[l] == addr[l*AW +: AW]);
    end
  end
endmodule

// File: rtl/smem_bank.sv
// One bank: word storage, lock bits and lock owners. At most one row is
// touched per pass because the picker only serves one word per bank.
module smem_bank
  import smem_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int AW      = 8,
  parameter int BW      = 5,
  parameter int DW      = 32,
  parameter int ROWS    = 8,
  parameter int BANK_ID = 0,
  localparam int RW     = AW - BW,
  localparam int LW     = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    served,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*2-1:0]  op,
  input  logic [LANES*DW-1:0] wdata,
  output logic [DW-1:0]       rdata,
  output logic [LANES-1:0]    pred
);
  logic [DW-1:0]    mem_q   [ROWS];
  logic [LW-1:0]    owner_q [ROWS];
  logic [ROWS-1:0]  lock_q;

  logic [LANES-1:0] sel;
  logic [RW-1:0]    row;
  logic             found;
  logic             we, granted, unlock;
  logic [DW-1:0]    wd;
  logic [LW-1:0]    new_owner;
  logic [LANES-1:0] gmask;

  always_comb begin
    sel   = '0;
    row   = '0;
    found = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (served[l] && addr[l*AW +: BW] == BW'(BANK_ID)) begin
        sel[l] = 1'b1;
        if (!found) begin
          row   = addr[l*AW + BW +: RW];
          found = 1'b1;
        end
      end
    end
  end

  assign rdata = mem_q[row];

  always_comb begin
    we        = 1'b0;
    wd        = '0;
    granted   = 1'b0;
    unlock    = 1'b0;
    new_owner = '0;
    pred      = '0;
    gmask     = '0;
    for (int l = 0; l < LANES; l++) begin
      if (sel[l]) begin
        case (smem_op_e'(op[l*2 +: 2]))
          OP_LD: pred[l] = 1'b1;
          OP_ST: begin
            pred[l] = 1'b1;
            we      = 1'b1;
            wd      = wdata[l*DW +: DW];
          end
          OP_LDLK: begin
            if (!lock_q[row] && !granted) begin
              granted   = 1'b1;
              gmask[l]  = 1'b1;
              pred[l]   = 1'b1;
              new_owner = LW'(l);
            end
          end
          default: begin
            if (lock_q[row] && owner_q[row] == LW'(l)) begin
              pred[l] = 1'b1;
              we      = 1'b1;
              wd      = wdata[l*DW +: DW];
              unlock  = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      for (int r = 0; r < ROWS; r++) begin
        mem_q[r]   <= '0;
        owner_q[r] <= '0;
      end
    end else begin
      if (we) mem_q[row] <= wd;
      if (granted) begin
        lock_q[row]  <= 1'b1;
        owner_q[row] <= new_owner;
      end
      if (unlock) lock_q[row] <= 1'b0;
    end
  end

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gmask));

  assert_grant_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    granted |=> lock_q[$past(row)]);
endmodule

// File: rtl/smem_banked.sv
module smem_banked #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROWS  = 8,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = BW + RW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*2-1:0]  req_op,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                busy,
  output logic [LANES-1:0]    rsp_valid,
  output logic [LANES-1:0]    rsp_pred,
  output logic [LANES*DW-1:0] rsp_data
);
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*2-1:0]  op_q;
  logic [LANES*DW-1:0] wdata_q;

  logic [LANES-1:0]    served;
  logic [DW-1:0]       bank_rdata [BANKS];
  logic [LANES-1:0]    bank_pred  [BANKS];
  logic [LANES-1:0]    pred_all;
  logic [LANES*DW-1:0] lane_data;
  logic                accept;

  assign busy      = |pend_q;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  smem_pick #(.LANES(LANES), .AW(AW), .BW(BW)) u_pick (
    .pending(pend_q),
    .addr   (addr_q),
    .served (served)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    smem_bank #(
      .LANES(LANES), .AW(AW), .BW(BW), .DW(DW), .ROWS(ROWS), .BANK_ID(b)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .served(served),
      .addr  (addr_q),
      .op    (op_q),
      .wdata (wdata_q),
      .rdata (bank_rdata[b]),
      .pred  (bank_pred[b])
    );
  end

  always_comb begin
    pred_all = '0;
    for (int b = 0; b < BANKS; b++) pred_all = pred_all | bank_pred[b];
    for (int l = 0; l < LANES; l++)
      lane_data[l*DW +: DW] = bank_rdata[addr_q[l*AW +: BW]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      addr_q    <= '0;
      op_q      <= '0;
      wdata_q   <= '0;
      rsp_valid <= '0;
      rsp_pred  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= served;
      rsp_pred  <= pred_all & served;
      rsp_data  <= lane_data;
      if (accept) begin
        pend_q  <= req_active;
        addr_q  <= req_addr;
        op_q    <= req_op;
        wdata_q <= req_wdata;
      end else begin
        pend_q <= pend_q & ~served;
      end
    end
  end

  assert_served_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (served & ~pend_q) == '0);

  assert_pass_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (served != '0));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_active != '0)) |=> busy);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (rsp_valid == '0));
endmodule

// File: tb/smem_banked_tb.sv
`timescale 1ns/1ps
module smem_banked_tb;
  localparam int L  = 4;
  localparam int B  = 4;
  localparam int R  = 4;
  localparam int D  = 16;
  localparam int AW = 4;
  localparam int W  = B * R;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, busy;
  logic [L-1:0]  req_active, rsp_valid, rsp_pred;
  logic [L*AW-1:0] req_addr;
  logic [L*2-1:0]  req_op;
  logic [L*D-1:0]  req_wdata, rsp_data;

  smem_banked #(.LANES(L), .BANKS(B), .ROWS(R), .DW(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .req_op(req_op),
    .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_pred(rsp_pred), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;

  logic [D-1:0] mdata [W];
  bit           mlock [W];
  int           mown  [W];

  logic [L-1:0] w_act;
  int           w_addr [L];
  int           w_op   [L];
  logic [D-1:0] w_wd   [L];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_warp();
    int           e_pass [L];
    logic [D-1:0] e_data [L];
    bit           e_pred [L];
    int           firstl [L];
    logic [D-1:0] sdata [W];
    bit           slock [W];
    int           sown  [W];
    bit           gf    [W];
    int           g_pass [L];
    int           g_cnt  [L];
    logic [D-1:0] g_data [L];
    bit           g_pred [L];
    string        ptag;

    sdata = mdata; slock = mlock; sown = mown;
    for (int i = 0; i < W; i++) gf[i] = 1'b0;
    for (int l = 0; l < L; l++) begin
      firstl[l] = l;
      for (int j = 0; j < l; j++)
        if (w_act[j] && w_addr[j] == w_addr[l] && firstl[l] == l) firstl[l] = j;
    end
    for (int l = 0; l < L; l++) begin
      int cnt = 0;
      for (int j = 0; j < firstl[l]; j++)
        if (w_act[j] && firstl[j] == j && (w_addr[j] % B) == (w_addr[l] % B)) cnt++;
      e_pass[l] = cnt + 1;
    end
    for (int l = 0; l < L; l++) begin
      int w = w_addr[l];
      e_data[l] = sdata[w];
      e_pred[l] = 1'b0;
      if (w_act[l]) begin
        case (w_op[l])
          0: e_pred[l] = 1'b1;
          1: begin e_pred[l] = 1'b1; mdata[w] = w_wd[l]; end
          2: if (!slock[w] && !gf[w]) begin
               gf[w] = 1'b1; e_pred[l] = 1'b1; mlock[w] = 1'b1; mown[w] = l;
             end
          default: if (slock[w] && sown[w] == l) begin
               e_pred[l] = 1'b1; mdata[w] = w_wd[l]; mlock[w] = 1'b0;
             end
        endcase
      end
    end

    @(negedge clk);
    req_valid  = 1'b1;
    req_active = w_act;
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW] = AW'(w_addr[l]);
      req_op[l*2 +: 2]     = 2'(w_op[l]);
      req_wdata[l*D +: D]  = w_wd[l];
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (w_act != '0) chk(busy && !req_ready, "R2", "busy after accept", busy, 1);
    for (int l = 0; l < L; l++) begin g_cnt[l] = 0; g_pass[l] = 0; g_data[l] = '0; g_pred[l] = 0; end
    for (int k = 1; k <= L + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      for (int l = 0; l < L; l++) if (rsp_valid[l]) begin
        g_cnt[l]++;
        g_pass[l] = k;
        g_data[l] = rsp_data[l*D +: D];
        g_pred[l] = rsp_pred[l];
      end
    end
    chk(!busy && req_ready, "R2", "ready after replay", busy, 0);
    for (int l = 0; l < L; l++) begin
      chk(g_cnt[l] == (w_act[l] ? 1 : 0), "R5", $sformatf("lane %0d result count", l),
          g_cnt[l], w_act[l] ? 1 : 0);
      if (w_act[l]) begin
        chk(g_pass[l] == e_pass[l], "R3", $sformatf("lane %0d pass", l), g_pass[l], e_pass[l]);
        chk(g_data[l] == e_data[l], "R4", $sformatf("lane %0d data", l), g_data[l], e_data[l]);
        case (w_op[l])
          2: ptag = "R7 R8";
          3: ptag = "R9";
          default: ptag = "R10";
        endcase
        chk(g_pred[l] == e_pred[l], ptag, $sformatf("lane %0d pred", l), g_pred[l], e_pred[l]);
      end
    end
  endtask

  task automatic set_lane(input int l, input bit a, input int ad, input int op,
                          input int wd);
    w_act[l] = a; w_addr[l] = ad; w_op[l] = op; w_wd[l] = D'(wd);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < W; i++) begin mdata[i] = '0; mlock[i] = 0; mown[i] = 0; end
    rst_n = 1'b0; req_valid = 1'b0; req_active = '0; req_addr = '0;
    req_op = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_ready && rsp_valid == '0, "R10", "reset idle", busy, 0);

    // R10 reset contents and R4 broadcast: four lanes load word 6
    for (int l = 0; l < L; l++) set_lane(l, 1, 6, 0, 0);
    run_warp();
    // R1 consecutive words land in distinct banks: one pass of stores
    for (int l = 0; l < L; l++) set_lane(l, 1, l, 1, 16'h1100 + l);
    run_warp();
    // R3 four-way conflict in bank 0
    for (int l = 0; l < L; l++) set_lane(l, 1, 4 * l, 1, 16'h2200 + l);
    run_warp();
    for (int l = 0; l < L; l++) set_lane(l, 1, 12 - 4 * l, 0, 0);
    run_warp();
    // R3 interleaved words in one bank: lanes 0,2 then lanes 1,3
    set_lane(0, 1, 4, 0, 0); set_lane(1, 1, 0, 0, 0);
    set_lane(2, 1, 4, 0, 0); set_lane(3, 1, 0, 0, 0);
    run_warp();
    // R6 several writers on one word, then read it back
    for (int l = 0; l < L; l++) set_lane(l, 1, 9, 1, 16'h3300 + l);
    run_warp();
    for (int l = 0; l < L; l++) set_lane(l, l == 1, 9, 0, 0);
    run_warp();
    // R7 two lanes contend for word 5
    set_lane(0, 1, 5, 2, 0); set_lane(1, 1, 5, 2, 0);
    set_lane(2, 0, 0, 0, 0); set_lane(3, 0, 0, 0, 0);
    run_warp();
    // R8 and R9: retry by a loser and unlock by a non-owner both fail
    set_lane(0, 0, 0, 0, 0); set_lane(1, 1, 5, 0, 0);
    set_lane(2, 1, 5, 2, 0); set_lane(3, 1, 5, 3, 16'hAAAA);
    run_warp();
    // R9 owner unlocks with a new value
    set_lane(0, 1, 5, 3, 16'h1234); set_lane(1, 0, 0, 0, 0);
    set_lane(2, 0, 0, 0, 0); set_lane(3, 0, 0, 0, 0);
    run_warp();
    // R7 retry now succeeds and sees the unlocked value
    set_lane(0, 0, 0, 0, 0); set_lane(2, 1, 5, 2, 0); set_lane(3, 1, 5, 0, 0);
    run_warp();

    for (int n = 0; n < 2500; n++) begin
      for (int l = 0; l < L; l++)
        set_lane(l, $urandom_range(0, 3) != 0, $urandom_range(0, W - 1),
                 $urandom_range(0, 3), $urandom_range(0, 65535));
      run_warp();
    end
    summary();
  end
endmodule